// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block sends 32-bit words over a three-wire synchronous serial link: a free-running bit clock, an active-low frame sync and a serial data line. The bit clock comes from the system clock through an integer divider. A host writes a word with a one-cycle strobe. At the next rising bit-clock edge the block pulls frame sync low for exactly one bit period. After a programmable gap of 0, 1 or 2 bit periods, it shifts the word out most significant bit first.

Configuration is written separately. The writable fields are the half-period of the bit clock, counted in system clocks, and the data delay. An init strobe re-arms a one-word discard: after reset or init, the first word the host writes is dropped instead of sent. A host that needs the link primed sends a dummy word first. Status outputs report a frame in flight, a one-cycle completion pulse and a sticky flag for writes that were rejected.

Top module: `fsw_tx`

## Requirements
- R1: A frame carries one 32-bit word. Bits go out in the order bit 31 down to bit 0, and each bit is held for one full bit period.
- R2: Frame sync (`fs_n_o`) goes low at a rising edge of `sclk_o` and stays low for exactly one bit period. At all other times it is high.
- R3: `sd_o` changes only in the cycle where `sclk_o` rises. It is low whenever no frame is in flight.
- R4: Bit 31 starts 0, 1 or 2 bit periods after the falling edge of frame sync. This is set by the 2-bit delay field `cfg_dly_i`: field value 3 acts as 2, and the reset value is 1. The setting in force at frame start applies to the whole frame.
- R5: `sclk_o` runs all the time. Each half-period lasts N system clocks, where N is the divider value, 0 acts as 1, and the reset value is `DEF_HALF`. A newly written divider is taken up only at a rising edge where no frame is pending or running.
- R6: After reset and after every `init_i` pulse, the next word write that finds the block idle is discarded. It produces no frame and no busy.
- R7: `busy_o` rises in the cycle after an accepted write. It stays high until the rising edge that ends the bit-0 period. At that same edge `sd_o` returns low and `done_o` is high for exactly one system cycle.
- R8: A word write while `busy_o` is high is rejected and leaves the frame in flight unchanged. It sets `overrun_o`, which stays set until `init_i`. `init_i` clears `overrun_o` and takes precedence over a write in the same cycle.
- R9: While reset is held, and on release, `sclk_o`, `sd_o`, `busy_o`, `done_o` and `overrun_o` are low and `fs_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_i | input | 1 | Re-arms the one-word discard and clears overrun |
| cfg_we_i | input | 1 | Write strobe for the divider and delay fields |
| cfg_half_i | input | CNT_W | Bit-clock half-period in system clocks |
| cfg_dly_i | input | 2 | Data delay in bit periods (3 acts as 2) |
| word_we_i | input | 1 | Word write strobe |
| word_i | input | WORD_W | Word to send |
| sclk_o | output | 1 | Bit clock |
| fs_n_o | output | 1 | Active-low frame sync |
| sd_o | output | 1 | Serial data |
| busy_o | output | 1 | Frame pending or in flight |
| done_o | output | 1 | One-cycle pulse when a frame ends |
| overrun_o | output | 1 | Sticky flag for rejected writes |

## Verification
A wrong slot count or latched delay shows up on `sd_o` at the first bit-clock rising edge after frame sync. That is one bit period after the fault at most. A lost or extra frame shows at the next rising edge, as a missing or extra frame-sync pulse. A divider taken up at the wrong time changes the `sclk_o` edge pattern within one half-period. A bad discard or overrun flag shows on `busy_o` or `overrun_o` in the cycle after the write. The bench replays every cycle against a behavioural model, and it also decodes the words off the three pins.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_RUN  = 2'd2
  } fsw_state_e;
endpackage

// File: rtl/fsw_bitclk.sv
module fsw_bitclk #(
  parameter int CNT_W    = 8,
  parameter int DEF_HALF = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] half_i,
  input  logic             upd_i,
  output logic             sclk_o,
  output logic             rise_o
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] RHALF = CNT_W'(DEF_HALF);

  logic [CNT_W-1:0] cnt_q, cnt_d, half_q, half_d;
  logic             sclk_q, sclk_d;
  logic             wrap;

  assign wrap   = (cnt_q == (half_q - ONE));
  assign rise_o = wrap & ~sclk_q;
  assign sclk_o = sclk_q;

  always_comb begin
    cnt_d  = wrap ? '0 : (cnt_q + ONE);
    sclk_d = sclk_q ^ wrap;
    half_d = half_q;
    if (rise_o && upd_i) half_d = half_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      half_q <= RHALF;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      half_q <= half_d;
    end
  end

  // R5: the divider in use is never zero
  a_r5_half_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q != '0);
endmodule

// File: rtl/fsw_frame.sv
module fsw_frame #(
  parameter int WORD_W = 32,
  parameter int SLOT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        dly_i,
  output logic              fs_n_o,
  output logic              sd_o,
  output logic              fin_o
);
  localparam logic [SLOT_W-1:0] WLEN = SLOT_W'(WORD_W);
  localparam logic [SLOT_W-1:0] SONE = SLOT_W'(1);

  logic              run_q, run_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [1:0]        dly_q, dly_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              fs_n_q, fs_n_d, sd_q, sd_d;
  logic [SLOT_W-1:0] nxt, dly_ext, last;

  assign nxt     = slot_q + SONE;
  assign dly_ext = SLOT_W'(dly_q);
  assign last    = dly_ext + WLEN;
  assign fin_o   = rise_i & run_q & (nxt == last);
  assign fs_n_o  = fs_n_q;
  assign sd_o    = sd_q;

  always_comb begin
    run_d  = run_q;
    slot_d = slot_q;
    dly_d  = dly_q;
    sh_d   = sh_q;
    fs_n_d = fs_n_q;
    sd_d   = sd_q;
    if (rise_i) begin
      if (start_i) begin
        run_d  = 1'b1;
        slot_d = '0;
        fs_n_d = 1'b0;
        dly_d  = dly_i;
        if (dly_i == 2'd0) begin
          sd_d = word_i[WORD_W-1];
          sh_d = word_i << 1;
        end else begin
          sd_d = 1'b0;
          sh_d = word_i;
        end
      end else if (run_q) begin
        slot_d = nxt;
        fs_n_d = 1'b1;
        if (fin_o) begin
          run_d = 1'b0;
          sd_d  = 1'b0;
        end else if (nxt >= dly_ext) begin
          sd_d = sh_q[WORD_W-1];
          sh_d = sh_q << 1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      dly_q  <= 2'd0;
      sh_q   <= '0;
      fs_n_q <= 1'b1;
      sd_q   <= 1'b0;
    end else begin
      run_q  <= run_d;
      slot_q <= slot_d;
      dly_q  <= dly_d;
      sh_q   <= sh_d;
      fs_n_q <= fs_n_d;
      sd_q   <= sd_d;
    end
  end

  // R2: sync is low only in the first slot of a running frame
  a_r2_fs_first_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_n_q |-> (run_q && slot_q == '0));
  // R1: slot counter never passes the end of the frame
  a_r1_slot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (slot_q < last));
endmodule

// File: rtl/fsw_tx.sv
module fsw_tx #(
  parameter int WORD_W   = 32,
  parameter int CNT_W    = 8,
  parameter int DEF_HALF = 8,
  parameter int DEF_DLY  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              cfg_we_i,
  input  logic [CNT_W-1:0]  cfg_half_i,
  input  logic [1:0]        cfg_dly_i,
  input  logic              word_we_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sclk_o,
  output logic              fs_n_o,
  output logic              sd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              overrun_o
);
  import fsw_pkg::*;

  localparam int SLOT_W = $clog2(WORD_W + 4) + 1;
  localparam logic [CNT_W-1:0] RHALF = CNT_W'(DEF_HALF);
  localparam logic [1:0]       RDLY  = 2'(DEF_DLY);

  logic rs1_q, rs2_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_n = rs2_q;

  fsw_state_e        st_q, st_d;
  logic [CNT_W-1:0]  half_cfg_q, half_cfg_d, half_eff;
  logic [1:0]        dly_cfg_q, dly_cfg_d;
  logic              skip_q, skip_d, ovr_q, ovr_d, done_q, done_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              rise, fin;

  assign half_eff = (half_cfg_q == '0) ? CNT_W'(1) : half_cfg_q;

  fsw_bitclk #(.CNT_W(CNT_W), .DEF_HALF(DEF_HALF)) u_clk (
    .clk_i (clk_i), .rst_ni(rst_n), .half_i(half_eff),
    .upd_i (st_q == ST_IDLE), .sclk_o(sclk_o), .rise_o(rise)
  );

  fsw_frame #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_frm (
    .clk_i (clk_i), .rst_ni(rst_n), .rise_i(rise),
    .start_i(st_q == ST_PEND), .word_i(hold_q), .dly_i(dly_cfg_q),
    .fs_n_o(fs_n_o), .sd_o(sd_o), .fin_o(fin)
  );

  always_comb begin
    st_d       = st_q;
    half_cfg_d = half_cfg_q;
    dly_cfg_d  = dly_cfg_q;
    skip_d     = skip_q;
    ovr_d      = ovr_q;
    hold_d     = hold_q;
    done_d     = 1'b0;
    if (cfg_we_i) begin
      half_cfg_d = cfg_half_i;
      dly_cfg_d  = (cfg_dly_i == 2'd3) ? 2'd2 : cfg_dly_i;
    end
    case (st_q)
      ST_PEND: if (rise) st_d = ST_RUN;
      ST_RUN:  if (fin) begin
                 st_d   = ST_IDLE;
                 done_d = 1'b1;
               end
      default: ;
    endcase
    if (init_i) begin
      skip_d = 1'b1;
      ovr_d  = 1'b0;
    end else if (word_we_i) begin
      if (st_q != ST_IDLE) ovr_d = 1'b1;
      else if (skip_q)     skip_d = 1'b0;
      else begin
        st_d   = ST_PEND;
        hold_d = word_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      half_cfg_q <= RHALF;
      dly_cfg_q  <= RDLY;
      skip_q     <= 1'b1;
      ovr_q      <= 1'b0;
      done_q     <= 1'b0;
      hold_q     <= '0;
    end else begin
      st_q       <= st_d;
      half_cfg_q <= half_cfg_d;
      dly_cfg_q  <= dly_cfg_d;
      skip_q     <= skip_d;
      ovr_q      <= ovr_d;
      done_q     <= done_d;
      hold_q     <= hold_d;
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign overrun_o = ovr_q;

  // R2: sync falls together with a rising bit-clock edge
  a_r2_fs_at_rise: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(fs_n_o) |-> $rose(sclk_o));
  // R3: data moves only with a rising bit-clock edge
  a_r3_sd_at_rise: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(sd_o) |-> $rose(sclk_o));
  // R3: idle lines
  a_r3_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy_o |-> (!sd_o && fs_n_o));
  // R7: done is a single-cycle pulse that coincides with busy falling
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(done_o) |-> (!busy_o && $past(busy_o)));
  // R8: overrun is sticky until init
  a_r8_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    (overrun_o && !init_i) |=> overrun_o);
  // R6: a discarded write leaves the block idle
  a_r6_skip_idle: assert property (@(posedge clk_i) disable iff (!rst_n)
    (skip_q && word_we_i && !init_i && !busy_o) |=> !busy_o);
endmodule

// File: tb/fsw_tx_tb.sv
module fsw_tx_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        init_i, cfg_we_i, word_we_i;
  logic [7:0]  cfg_half_i;
  logic [1:0]  cfg_dly_i;
  logic [31:0] word_i;
  logic        sclk_o, fs_n_o, sd_o, busy_o, done_o, overrun_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fsw_tx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .cfg_we_i(cfg_we_i),
    .cfg_half_i(cfg_half_i), .cfg_dly_i(cfg_dly_i), .word_we_i(word_we_i),
    .word_i(word_i), .sclk_o(sclk_o), .fs_n_o(fs_n_o), .sd_o(sd_o),
    .busy_o(busy_o), .done_o(done_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_sync, m_cnt, m_half, m_st, m_cfg_half, m_cfg_dly;
  bit          m_sclk, m_fs, m_sd, m_done, m_skip, m_ovr;
  logic [31:0] m_hold;
  logic [1:0]  m_q[$];

  task automatic m_reset();
    m_cnt = 0; m_half = 8; m_st = 0; m_cfg_half = 8; m_cfg_dly = 1;
    m_sclk = 0; m_fs = 1; m_sd = 0; m_done = 0; m_skip = 1; m_ovr = 0;
    m_hold = '0; m_q.delete();
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_sync = 0;
      m_reset();
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bit rise, tog;
      int old_st, d, k;
      logic [1:0] e;
      tog    = (m_cnt == m_half - 1);
      rise   = tog && !m_sclk;
      old_st = m_st;
      m_done = 0;
      if (tog) begin m_cnt = 0; m_sclk = !m_sclk; end else m_cnt++;
      if (rise && old_st == 0) m_half = (m_cfg_half == 0) ? 1 : m_cfg_half;
      if (rise && old_st == 2) begin
        e = m_q.pop_front();
        m_fs = e[1]; m_sd = e[0];
        if (m_q.size() == 0) begin m_done = 1; m_st = 0; end
      end
      if (rise && old_st == 1) begin
        d = m_cfg_dly;
        m_fs = 0;
        m_sd = (d == 0) ? m_hold[31] : 1'b0;
        for (int n = 1; n <= d + 32; n++) begin
          k = n - d;
          m_q.push_back({1'b1, (k >= 0 && k < 32) ? m_hold[31-k] : 1'b0});
        end
        m_st = 2;
      end
      if (init_i) begin
        m_skip = 1; m_ovr = 0;
      end else if (word_we_i) begin
        if (old_st != 0) m_ovr = 1;
        else if (m_skip) m_skip = 0;
        else begin m_st = 1; m_hold = word_i; end
      end
      if (cfg_we_i) begin
        m_cfg_half = int'(cfg_half_i);
        m_cfg_dly  = (cfg_dly_i == 2'd3) ? 2 : int'(cfg_dly_i);
      end
    end
  end

  bit cmp_en = 0;
  // pin-level receiver
  bit          prev_sclk = 0;
  int          rx_slot = -1, rx_d = 1, rx_frames = 0;
  logic [31:0] rx_word, rx_exp;

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(sclk_o === m_sclk, "R5 sclk", {31'd0, sclk_o}, {31'd0, m_sclk});
      chk(fs_n_o === m_fs, "R2 fs_n", {31'd0, fs_n_o}, {31'd0, m_fs});
      chk(sd_o === m_sd, "R1 R3 sd", {31'd0, sd_o}, {31'd0, m_sd});
      chk(busy_o === (m_st != 0), "R7 busy", {31'd0, busy_o}, {31'd0, m_st != 0});
      chk(done_o === m_done, "R7 done", {31'd0, done_o}, {31'd0, m_done});
      chk(overrun_o === m_ovr, "R8 overrun", {31'd0, overrun_o}, {31'd0, m_ovr});
      if (sclk_o && !prev_sclk) begin
        if (!fs_n_o) rx_slot = 0;
        else if (rx_slot >= 0) rx_slot++;
        if (rx_slot >= rx_d && rx_slot < rx_d + 32)
          rx_word = {rx_word[30:0], sd_o};
        if (rx_slot == rx_d + 31) begin
          rx_frames++;
          chk(rx_word === rx_exp, "R1 R4 decoded word", rx_word, rx_exp);
          rx_slot = -1;
        end
      end
      prev_sclk = sclk_o;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] h, input logic [1:0] d);
    @(negedge clk);
    cfg_we_i = 1; cfg_half_i = h; cfg_dly_i = d;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    word_we_i = 1; word_i = w;
    @(negedge clk);
    word_we_i = 0;
  endtask

  task automatic pulse_init();
    @(negedge clk);
    init_i = 1;
    @(negedge clk);
    init_i = 0;
  endtask

  task automatic frame(input logic [31:0] w, input int d);
    rx_d = d; rx_exp = w;
    send(w);
    for (int i = 0; i < 5000 && !done_o; i++) @(negedge clk);
    chk(done_o === 1'b1, "R7 done seen", {31'd0, done_o}, 32'd1);
    cyc(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 0; init_i = 0; cfg_we_i = 0; word_we_i = 0;
    cfg_half_i = '0; cfg_dly_i = '0; word_i = '0;
    repeat (5) @(negedge clk);
    chk({sclk_o, fs_n_o, sd_o, busy_o, done_o, overrun_o} === 6'b010000,
        "R9 reset state", {26'd0, sclk_o, fs_n_o, sd_o, busy_o, done_o, overrun_o},
        32'h10);
    rst_ni = 1;
    cmp_en = 1;
    cyc(2);
    chk({sclk_o, fs_n_o, sd_o, busy_o, done_o, overrun_o} === 6'b010000,
        "R9 release state", {26'd0, sclk_o, fs_n_o, sd_o, busy_o, done_o, overrun_o},
        32'h10);
    cyc(4);
    // R6: first write after reset is dropped
    send(32'hDEAD_BEEF);
    chk(busy_o === 1'b0, "R6 discard after reset", {31'd0, busy_o}, 32'd0);
    cyc(60);
    chk(rx_frames == 0, "R6 no frame after reset", rx_frames, 0);
    frame(32'hA5C3_0F81, 1);               // R4 default delay 1
    cfg(8'd3, 2'd0);
    frame(32'h8000_0001, 0);               // R4 delay 0, R5 divider 3
    cfg(8'd3, 2'd2);
    frame(32'h1234_5678, 2);               // R4 delay 2
    cfg(8'd0, 2'd3);
    frame(32'hFFFF_FFFF, 2);               // R4 3 acts as 2, R5 0 acts as 1
    cfg(8'd5, 2'd1);
    // R8: write during a frame, divider change mid-frame (R5)
    rx_d = 1; rx_exp = 32'h0F0F_0F0F;
    send(32'h0F0F_0F0F);
    cyc(30);
    send(32'h1111_1111);
    chk(overrun_o === 1'b1, "R8 overrun set", {31'd0, overrun_o}, 32'd1);
    cfg(8'd2, 2'd1);
    for (int i = 0; i < 5000 && !done_o; i++) @(negedge clk);
    cyc(3);
    chk(overrun_o === 1'b1, "R8 overrun sticky", {31'd0, overrun_o}, 32'd1);
    pulse_init();
    chk(overrun_o === 1'b0, "R8 init clears", {31'd0, overrun_o}, 32'd0);
    send(32'h5555_5555);                   // R6 dropped after init
    cyc(40);
    chk(busy_o === 1'b0, "R6 discard after init", {31'd0, busy_o}, 32'd0);
    frame(32'h0000_0001, 1);
    chk(rx_frames == 6, "R6 frame count", rx_frames, 6);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule